// File: doc/BRIEF.md
# Programmable Feedback Delay Line

This block delays a stream of signed samples on their way from a beam pickup path to a kicker drive. The total delay has two parts. The coarse part is a whole number of samples, from 0 to 1023, taken from a circular buffer. The fine part is a fraction of a sample in sixteenths, produced by linear interpolation between two adjacent delayed samples. Together they let the loop delay be tuned so that the pickup-to-kicker phase stays inside the window that keeps the feedback negative. One machine turn is roughly 400 to 450 samples, so the coarse range spans more than a full turn.

Settings are written through a single strobe that loads the length, the fraction and a bypass bit together. The length can be changed while samples are flowing. After a change, the output is held at zero for as long as the buffer needs to refill with samples taken under the new length, so no stale or unwritten data reaches the kicker. In bypass, samples pass straight through with one register of latency. A sticky flag records any length change that arrived while an earlier change was still settling.

Top module: `fdl_delay_line`

## Requirements
- R1: Each cycle with `in_valid` high produces exactly one output: `out_valid` is high in the following cycle. A cycle without `in_valid` leaves `out_valid` low in the following cycle.
- R2: With bypass off, the fraction at 0 and no mute, the output for the n-th accepted sample equals the sample accepted L samples earlier, where L is the programmed length (0 to 1023). L = 0 gives the current input.
- R3: With bypass off and no mute, the output equals floor(((16 - f) * x[n-L] + f * x[n-L-1] + 8) / 16). Here f is the 4-bit fraction (0 to 15, in sixteenths) and x[k] is the k-th accepted sample. This is round to nearest, with halves rounded up.
- R4: The interpolated result is limited to the 16-bit signed range and never wraps. Full-scale inputs (32767 and -32768) come out unchanged when both neighbours are equal.
- R5: A `cfg_wr` cycle loads `cfg_len`, `cfg_frac` and `cfg_bypass`. A sample accepted in the same cycle still uses the old settings. Samples accepted in later cycles use the new ones.
- R6: A write whose length differs from the current length mutes the next L+1 accepted samples, where L is the new length. A muted sample gives `out_valid` high with `out_sample` = 0. A write that keeps the same length does not mute. After reset, the first accepted sample is muted.
- R7: With bypass on, `out_sample` is the sample accepted in the previous cycle, whether or not a mute is pending. The buffer keeps filling, and the mute count keeps running down.
- R8: `overlap_flag` goes high one cycle after a length-changing write that arrives while a mute count is still nonzero. It then stays high until reset. Length changes made after the mute has run out do not set it.
- R9: After reset, `out_valid`, `out_sample` and `overlap_flag` are 0, the length and fraction are 0, and bypass is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 16 | Signed input sample |
| cfg_wr | input | 1 | Setting load strobe |
| cfg_len | input | 10 | Coarse delay in samples |
| cfg_frac | input | 4 | Fine delay in sixteenths of a sample |
| cfg_bypass | input | 1 | Pass samples through undelayed |
| out_valid | output | 1 | Output sample qualifier |
| out_sample | output | 16 | Signed delayed sample |
| overlap_flag | output | 1 | Sticky: length changed while still settling |

## Verification
The input stream mixes full-scale positive and negative values with a pseudo-random ramp. This lets a wrong tap address, an off-by-one neighbour or a sign error in the blend show up as a distinct wrong value rather than a coincidental match. The lengths tested are 0, a few samples, roughly one turn and the 1023 maximum. The maximum checks wrap-around, where the older neighbour occupies the slot that is being overwritten. The fractions 0, 1, 4, 8 and 15 separate the coarse tap from the interpolation and expose rounding at the half-way point. Directed steps cover three cases: a fraction-only write (must not mute), a setting write in the same cycle as a sample (must apply later), and a second length change during settling (sets the sticky flag).

// File: rtl/fdl_pkg.sv
package fdl_pkg;
   localparam int unsigned DEF_SAMPLE_W = 16;
   localparam int unsigned DEF_LEN_W    = 10;
   localparam int unsigned DEF_FRAC_W   = 4;

   typedef enum logic {
      RND_FLOOR   = 1'b0,
      RND_NEAREST = 1'b1
   } round_mode_e;
endpackage

// File: rtl/fdl_store.sv
// Circular sample store with a write pointer and two read taps:
// the delayed sample (near) and its predecessor (far).
module fdl_store #(
   parameter int unsigned SAMPLE_W = fdl_pkg::DEF_SAMPLE_W,
   parameter int unsigned LEN_W    = fdl_pkg::DEF_LEN_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic signed [SAMPLE_W-1:0] wr_data,
   input  logic        [LEN_W-1:0]    tap_len,
   output logic signed [SAMPLE_W-1:0] near_smp,
   output logic signed [SAMPLE_W-1:0] far_smp
);
   localparam int unsigned DEPTH = 1 << LEN_W;

   logic signed [SAMPLE_W-1:0] mem [DEPTH];
   logic [LEN_W-1:0] wr_ptr;
   logic [LEN_W-1:0] near_addr;
   logic [LEN_W-1:0] far_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_ptr <= '0;
      else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   // At the maximum length the far tap lands on the slot being written
   // this cycle; it still holds the oldest sample, which is the one wanted.
   always_comb begin
      near_addr = wr_ptr - tap_len;
      far_addr  = near_addr - 1'b1;
      near_smp  = (tap_len == '0) ? wr_data : mem[near_addr];
      far_smp   = mem[far_addr];
   end
endmodule

// File: rtl/fdl_blend.sv
// Linear interpolation between two neighbouring samples, with a
// rounding choice and clamping to the sample range.
module fdl_blend #(
   parameter int unsigned       SAMPLE_W = fdl_pkg::DEF_SAMPLE_W,
   parameter int unsigned       FRAC_W   = fdl_pkg::DEF_FRAC_W,
   parameter fdl_pkg::round_mode_e RMODE = fdl_pkg::RND_NEAREST
) (
   input  logic signed [SAMPLE_W-1:0] near_smp,
   input  logic signed [SAMPLE_W-1:0] far_smp,
   input  logic        [FRAC_W-1:0]   frac,
   output logic signed [SAMPLE_W-1:0] result
);
   localparam int unsigned AW  = SAMPLE_W + FRAC_W + 2;
   localparam int          ONE = 1 << FRAC_W;
   localparam logic signed [AW-1:0] HI = AW'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
   localparam logic signed [AW-1:0] LO = ~HI;

   logic signed [AW-1:0] w_far, w_near, bias, acc, scaled;

   generate
      if (RMODE == fdl_pkg::RND_NEAREST) begin : g_nearest
         assign bias = AW'(ONE / 2);
      end else begin : g_floor
         assign bias = '0;
      end
   endgenerate

   always_comb begin
      w_far  = signed'(AW'(frac));
      w_near = AW'(ONE) - w_far;
      acc    = w_near * AW'(near_smp) + w_far * AW'(far_smp) + bias;
      scaled = acc >>> FRAC_W;
      if (scaled > HI)      result = HI[SAMPLE_W-1:0];
      else if (scaled < LO) result = LO[SAMPLE_W-1:0];
      else                  result = scaled[SAMPLE_W-1:0];
   end
endmodule

// File: rtl/fdl_ctrl.sv
// Holds the active settings, counts down the refill mute after a length
// change and keeps the sticky overlap flag.
module fdl_ctrl #(
   parameter int unsigned LEN_W  = fdl_pkg::DEF_LEN_W,
   parameter int unsigned FRAC_W = fdl_pkg::DEF_FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              cfg_wr,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [FRAC_W-1:0] cfg_frac,
   input  logic              cfg_bypass,
   output logic [LEN_W-1:0]  cur_len,
   output logic [FRAC_W-1:0] cur_frac,
   output logic              cur_byp,
   output logic              muting,
   output logic              overlap
);
   logic [LEN_W:0] settle;
   logic           len_change;

   assign len_change = cfg_wr && (cfg_len != cur_len);
   assign muting     = (settle != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_len  <= '0;
         cur_frac <= '0;
         cur_byp  <= 1'b0;
         settle   <= (LEN_W + 1)'(1);
         overlap  <= 1'b0;
      end else begin
         if (cfg_wr) begin
            cur_len  <= cfg_len;
            cur_frac <= cfg_frac;
            cur_byp  <= cfg_bypass;
         end
         if (len_change)
            settle <= {1'b0, cfg_len} + 1'b1;
         else if (in_valid && muting)
            settle <= settle - 1'b1;
         if (len_change && muting)
            overlap <= 1'b1;
      end
   end
endmodule

// File: rtl/fdl_delay_line.sv
module fdl_delay_line #(
   parameter int unsigned          SAMPLE_W = fdl_pkg::DEF_SAMPLE_W,
   parameter int unsigned          LEN_W    = fdl_pkg::DEF_LEN_W,
   parameter int unsigned          FRAC_W   = fdl_pkg::DEF_FRAC_W,
   parameter fdl_pkg::round_mode_e RMODE    = fdl_pkg::RND_NEAREST
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic signed [SAMPLE_W-1:0] in_sample,
   input  logic                       cfg_wr,
   input  logic        [LEN_W-1:0]    cfg_len,
   input  logic        [FRAC_W-1:0]   cfg_frac,
   input  logic                       cfg_bypass,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_sample,
   output logic                       overlap_flag
);
   generate
      if (SAMPLE_W < 2 || SAMPLE_W > 32) begin : g_bad_sw
         $error("fdl_delay_line: SAMPLE_W must be 2..32");
      end
      if (LEN_W < 1 || LEN_W > 14) begin : g_bad_lw
         $error("fdl_delay_line: LEN_W must be 1..14");
      end
      if (FRAC_W < 1 || FRAC_W > 8) begin : g_bad_fw
         $error("fdl_delay_line: FRAC_W must be 1..8");
      end
   endgenerate

   logic [LEN_W-1:0]          cur_len;
   logic [FRAC_W-1:0]         cur_frac;
   logic                      cur_byp;
   logic                      muting;
   logic signed [SAMPLE_W-1:0] near_smp, far_smp, blended;

   fdl_ctrl #(.LEN_W(LEN_W), .FRAC_W(FRAC_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .cfg_wr(cfg_wr), .cfg_len(cfg_len), .cfg_frac(cfg_frac),
      .cfg_bypass(cfg_bypass), .cur_len(cur_len), .cur_frac(cur_frac),
      .cur_byp(cur_byp), .muting(muting), .overlap(overlap_flag)
   );

   fdl_store #(.SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_data(in_sample),
      .tap_len(cur_len), .near_smp(near_smp), .far_smp(far_smp)
   );

   fdl_blend #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .RMODE(RMODE)) u_blend (
      .near_smp(near_smp), .far_smp(far_smp), .frac(cur_frac), .result(blended)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            if (cur_byp)     out_sample <= in_sample;
            else if (muting) out_sample <= '0;
            else             out_sample <= blended;
         end
      end
   end
endmodule

// File: rtl/fdl_delay_line_chk.sv
module fdl_delay_line_chk #(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned LEN_W    = 10,
   parameter int unsigned FRAC_W   = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       in_valid,
   input logic signed [SAMPLE_W-1:0] in_sample,
   input logic                       cfg_wr,
   input logic        [LEN_W-1:0]    cfg_len,
   input logic                       out_valid,
   input logic signed [SAMPLE_W-1:0] out_sample,
   input logic                       overlap_flag,
   input logic        [LEN_W-1:0]    cur_len,
   input logic        [FRAC_W-1:0]   cur_frac,
   input logic                       cur_byp,
   input logic                       muting
);
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r2_zero_len_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cur_byp && !muting && cur_len == '0 && cur_frac == '0)
      |=> out_sample == $past(in_sample));
   a_r6_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cur_byp && muting) |=> out_sample == '0);
   a_r7_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cur_byp) |=> out_sample == $past(in_sample));
   a_r8_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_len != cur_len && muting) |=> overlap_flag);
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overlap_flag |=> overlap_flag);
endmodule

bind fdl_delay_line fdl_delay_line_chk #(
   .SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W), .FRAC_W(FRAC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
   .cfg_wr(cfg_wr), .cfg_len(cfg_len), .out_valid(out_valid),
   .out_sample(out_sample), .overlap_flag(overlap_flag),
   .cur_len(cur_len), .cur_frac(cur_frac), .cur_byp(cur_byp), .muting(muting)
);

// File: tb/tb_fdl_delay_line.sv
module tb_fdl_delay_line;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_sample = '0;
   logic               cfg_wr = 1'b0;
   logic [9:0]         cfg_len = '0;
   logic [3:0]         cfg_frac = '0;
   logic               cfg_bypass = 1'b0;
   logic               out_valid;
   logic signed [15:0] out_sample;
   logic               overlap_flag;

   always #10 clk = ~clk;

   fdl_delay_line dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .cfg_wr(cfg_wr), .cfg_len(cfg_len), .cfg_frac(cfg_frac),
      .cfg_bypass(cfg_bypass), .out_valid(out_valid), .out_sample(out_sample),
      .overlap_flag(overlap_flag)
   );

   // Table: one setting write, then a run of samples under it.
   localparam int NSTEP = 8;
   localparam int T_LEN [NSTEP] = '{0, 3, 3, 5, 5, 450, 1023, 1};
   localparam int T_FRAC[NSTEP] = '{0, 0, 8, 15, 15, 1, 4, 8};
   localparam int T_BYP [NSTEP] = '{0, 0, 0, 0, 1, 0, 0, 0};
   localparam int T_N   [NSTEP] = '{20, 10, 12, 12, 6, 470, 1040, 10};

   int vectors = 0;
   int errors  = 0;

   // Reference model state
   int m_len = 0, m_frac = 0, m_byp = 0, m_cnt = 1, m_flag = 0, n = 0;
   int hist [4096];
   int k_pat = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int pattern(input int k);
      if (k % 5 == 0)      return 32767;
      else if (k % 7 == 0) return -32768;
      else                 return ((k * 2749 + 1234) % 60000) - 30000;
   endfunction

   function automatic int expect_out(input int x);
      int a, b, acc, y;
      if (m_byp != 0) return x;
      if (m_cnt != 0) return 0;
      a = (m_len == 0) ? x : hist[n - m_len];
      b = hist[n - m_len - 1];
      acc = (16 - m_frac) * a + m_frac * b + 8;
      y = acc >>> 4;
      if (y > 32767) y = 32767;
      if (y < -32768) y = -32768;
      return y;
   endfunction

   // One transfer: optional sample and optional setting write in the same cycle.
   task automatic xfer(input bit vs, input int x, input bit vc,
                       input int len, input int frac, input int byp, input string req);
      int exp;
      exp = expect_out(x);
      @(negedge clk);
      in_valid = vs; in_sample = 16'(x);
      cfg_wr = vc; cfg_len = 10'(len); cfg_frac = 4'(frac); cfg_bypass = byp[0];
      if (vs) begin
         hist[n] = x; n++;
         if (m_cnt > 0) m_cnt--;
      end
      if (vc) begin
         if (len != m_len) begin
            if (m_cnt > 0) m_flag = 1;
            m_cnt = len + 1;
         end
         m_len = len; m_frac = frac; m_byp = byp;
      end
      @(negedge clk);
      in_valid = 1'b0; cfg_wr = 1'b0;
      if (vs) begin
         check(out_valid == 1'b1, {req, "/R1 valid"}, int'(out_valid), 1);
         check(int'(out_sample) == exp, req, int'(out_sample), exp);
      end
      check(int'(overlap_flag) == m_flag, "R8 flag", int'(overlap_flag), m_flag);
      @(negedge clk);
      check(out_valid == 1'b0, "R1 idle", int'(out_valid), 0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
      check(out_sample == 16'sd0, "R9 out_sample", int'(out_sample), 0);
      check(overlap_flag == 1'b0, "R9 flag", int'(overlap_flag), 0);
      // R6: first sample after reset muted; R2 at length 0 thereafter
      xfer(1, 1111, 0, 0, 0, 0, "R6 reset mute");
      xfer(1, -2222, 0, 0, 0, 0, "R2 len0");

      for (int s = 0; s < NSTEP; s++) begin
         xfer(0, 0, 1, T_LEN[s], T_FRAC[s], T_BYP[s], "R5 cfg");
         for (int i = 0; i < T_N[s]; i++) begin
            string tg;
            if (T_BYP[s] != 0)       tg = "R7 bypass";
            else if (m_cnt != 0)     tg = "R6 mute";
            else if (T_FRAC[s] != 0) tg = "R3 interp";
            else                     tg = "R2 coarse";
            xfer(1, pattern(k_pat), 0, 0, 0, 0, tg);
            k_pat++;
         end
      end

      // R4: equal full-scale neighbours come through without wrap
      xfer(0, 0, 1, 1, 7, 0, "R4 cfg");
      for (int i = 0; i < 4; i++) xfer(1, 32767, 0, 0, 0, 0, "R4 pos full scale");
      for (int i = 0; i < 4; i++) xfer(1, -32768, 0, 0, 0, 0, "R4 neg full scale");

      // R5: settings written with a sample apply only to later samples
      xfer(1, 500, 1, 1, 7, 1, "R5 same-cycle old cfg");
      xfer(1, 600, 0, 0, 0, 0, "R5 new cfg bypass");
      xfer(1, 700, 1, 1, 3, 0, "R5 same-cycle still bypass");
      xfer(1, 800, 0, 0, 0, 0, "R3 after same-len write");

      // R8: change after settling keeps flag low; change while settling sets it
      xfer(0, 0, 1, 10, 0, 0, "R8 first change");
      xfer(1, 11, 0, 0, 0, 0, "R6 mute");
      xfer(1, 12, 0, 0, 0, 0, "R6 mute");
      xfer(0, 0, 1, 20, 0, 0, "R8 overlap change");
      for (int i = 0; i < 25; i++) xfer(1, 100 + i, 0, 0, 0, 0, "R8 sticky run");
      check(overlap_flag == 1'b1, "R8 sticky", int'(overlap_flag), 1);

      // R9: reset clears the flag and settings
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check(overlap_flag == 1'b0, "R9 flag after reset", int'(overlap_flag), 0);
      check(out_valid == 1'b0, "R9 valid after reset", int'(out_valid), 0);
      rst_n = 1'b1;
      m_len = 0; m_frac = 0; m_byp = 0; m_cnt = 1; m_flag = 0;
      xfer(1, 4321, 0, 0, 0, 0, "R9 R6 mute after reset");
      xfer(1, -4321, 0, 0, 0, 0, "R9 len0 after reset");

      summary();
      $finish;
   end
endmodule